// File: doc/BRIEF.md
# Isochronous Cycle Timer and Monitor

This block keeps the bus cycle timer of a serial audio/video bus node. The timer has three fields: a seconds field, a cycle-count field and a cycle-offset field. The offset counts clock ticks inside one isochronous cycle. The count numbers the cycles inside one second. The seconds field counts whole seconds. The block advances the count in one of two ways. By default it advances when the offset rolls over. With the source select set high, it advances on the rising edge of an external cycle strobe, which also forces the offset back to zero.

Around the timer the block watches each isochronous cycle and raises event flags for the node's interrupt register. The flags cover these events:
- a cycle is pending
- a cycle-start packet was sent or received
- the cycle ended with a fair gap
- two rollovers passed with no cycle start (lost cycle)
- a cycle ran past its time budget (timeout)
- the seconds field advanced

A timeout also withdraws the node from the cycle-master role until the host drops and re-asserts its master request. Packet handling and gap detection happen elsewhere. This block only sees their pulses.

The clock is taken to be the timer tick. With the default parameters (3072 offset values, 8000 cycles, a 3072-tick timeout) one cycle lasts 125 µs at 24.576 MHz.

Top module: `cycle_timer_mon`

## Requirements
- R1: While `tick_en_i` is high, the offset field (bits [OFF_W-1:0] of `timer_o`) rises by one on each clock and wraps from OFFSET_MOD-1 to 0. While `tick_en_i` is low and no strobe acts, the offset holds its value.
- R2: With `src_sel_i` low, the count field (next CNT_W bits above the offset) rises by one on each offset rollover. The count wraps from COUNT_MOD-1 to 0, and that wrap adds one to the seconds field (top SEC_W bits).
- R3: With `src_sel_i` high, a rising edge of `ext_cycle_i` clears the offset and advances the count on the third clock edge after the input rises, because the input is synchronised first. In this mode an offset rollover leaves the count unchanged. With `src_sel_i` low, `ext_cycle_i` has no effect.
- R4: `cyc_pending_o` is a level. It goes high on the edge at which the offset becomes zero, whether by rollover or by strobe. It goes low on the edge at which the cycle ends, either by done or by timeout. If both happen on the same edge, setting wins.
- R5: `cyc_started_o` is a one-clock pulse on the edge after `start_pkt_i` is sampled high. `cyc_done_o` is a one-clock pulse when `fair_gap_i` is sampled while a cycle opened by a start packet is still open. A fair gap with no open cycle gives no pulse.
- R6: While `master_active_o` is low, the second offset-zero event with no start packet since the previous one gives a one-clock `cyc_lost_o` pulse. A start packet clears this history.
- R7: When TMO_TICKS clock edges follow a start packet with no fair gap, `cyc_timeout_o` pulses for one clock and the cycle closes. `master_active_o` then stays low until `cycle_master_i` has been low for at least one clock and is high again.
- R8: `sec_inc_o` pulses for one clock on the edge at which the seconds field advances.
- R9: After reset the timer reads zero, every event output is low, and `master_active_o` follows `cycle_master_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Lets the offset field advance |
| src_sel_i | input | 1 | 1: count follows external strobe; 0: count follows offset rollover |
| ext_cycle_i | input | 1 | External cycle strobe, asynchronous |
| cycle_master_i | input | 1 | Host request for the cycle-master role |
| start_pkt_i | input | 1 | Pulse: cycle-start packet sent or received |
| fair_gap_i | input | 1 | Pulse: fair gap detected on the bus |
| timer_o | output | SEC_W+CNT_W+OFF_W | Packed {seconds, count, offset} |
| cyc_pending_o | output | 1 | Cycle pending level |
| cyc_started_o | output | 1 | Cycle started pulse |
| cyc_done_o | output | 1 | Cycle done pulse |
| cyc_lost_o | output | 1 | Cycle lost pulse |
| cyc_timeout_o | output | 1 | Cycle timeout pulse |
| sec_inc_o | output | 1 | Seconds incremented pulse |
| master_active_o | output | 1 | Cycle-master role in effect |

## Verification
The hardest situations to reach from the ports are the seconds rollover and the timeout. At the default sizes, one takes millions of ticks and the other thousands. The bench therefore builds the block with a 4-value offset, a 3-value count and a 6-tick timeout. At these sizes a short table walks the timer through a seconds advance, and a directed sequence holds back the fair gap until the timeout fires. The lost-cycle case needs the node to be non-master and two rollovers with no start between them. The bench runs this case twice, once with a start packet placed between the rollovers to show that the history is cleared.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    typedef struct packed {
        logic started;
        logic done;
        logic lost;
        logic timeout;
    } cyc_evt_t;
endpackage

// File: rtl/cyc_edge_sync.sv
module cyc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;
endmodule

// File: rtl/cyc_timer_core.sv
module cyc_timer_core #(
    parameter int OFFSET_MOD = 3072,
    parameter int COUNT_MOD  = 8000,
    parameter int SEC_W      = 7,
    parameter int OFF_W      = $clog2(OFFSET_MOD),
    parameter int CNT_W      = $clog2(COUNT_MOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_sel_i,
    input  logic             strobe_rise_i,
    output logic [OFF_W-1:0] offset_o,
    output logic [CNT_W-1:0] count_o,
    output logic [SEC_W-1:0] sec_o,
    output logic             zero_evt_o,
    output logic             sec_inc_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFFSET_MOD - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COUNT_MOD - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] off;
        logic             sec_inc;
    } core_t;

    core_t core_d, core_q;
    logic  zero_d;
    logic  adv_cnt;

    always_comb begin
        core_d         = core_q;
        core_d.sec_inc = 1'b0;
        zero_d         = 1'b0;
        adv_cnt        = 1'b0;

        // Offset: a strobe in external mode overrides the tick
        if (src_sel_i && strobe_rise_i) begin
            core_d.off = '0;
            zero_d     = 1'b1;
            adv_cnt    = 1'b1;
        end else if (en_i) begin
            if (core_q.off == OFF_LAST) begin
                core_d.off = '0;
                zero_d     = 1'b1;
                adv_cnt    = !src_sel_i;
            end else begin
                core_d.off = core_q.off + OFF_W'(1);
            end
        end

        // Count and seconds
        if (adv_cnt) begin
            if (core_q.cnt == CNT_LAST) begin
                core_d.cnt     = '0;
                core_d.sec     = core_q.sec + SEC_W'(1);
                core_d.sec_inc = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign offset_o   = core_q.off;
    assign count_o    = core_q.cnt;
    assign sec_o      = core_q.sec;
    assign sec_inc_o  = core_q.sec_inc;
    assign zero_evt_o = zero_d;
endmodule

// File: rtl/cyc_monitor.sv
module cyc_monitor
    import cyc_pkg::*;
#(
    parameter int TMO_TICKS = 3072,
    parameter int TMO_W     = $clog2(TMO_TICKS)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     zero_evt_i,
    input  logic     start_pkt_i,
    input  logic     fair_gap_i,
    input  logic     master_req_i,
    output logic     pending_o,
    output cyc_evt_t evt_o,
    output logic     master_active_o
);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_TICKS - 1);

    typedef struct packed {
        logic             pending;
        logic             in_cyc;
        logic             one_roll;
        logic             master_en;
        logic [TMO_W-1:0] tmo_cnt;
        cyc_evt_t         evt;
    } mon_t;

    mon_t mon_d, mon_q;
    logic cyc_end;
    logic master_act;

    assign master_act = master_req_i & mon_q.master_en;

    always_comb begin
        mon_d             = mon_q;
        mon_d.evt         = '0;
        mon_d.evt.started = start_pkt_i;
        cyc_end           = 1'b0;

        // Re-arm the master role once the host withdraws its request
        if (!master_req_i) mon_d.master_en = 1'b1;

        // Cycle window: start opens, fair gap or timeout closes
        if (start_pkt_i) begin
            mon_d.in_cyc  = 1'b1;
            mon_d.tmo_cnt = '0;
        end else if (mon_q.in_cyc) begin
            if (fair_gap_i) begin
                mon_d.evt.done = 1'b1;
                mon_d.in_cyc   = 1'b0;
                cyc_end        = 1'b1;
            end else if (mon_q.tmo_cnt == TMO_LAST) begin
                mon_d.evt.timeout = 1'b1;
                mon_d.in_cyc      = 1'b0;
                mon_d.master_en   = 1'b0;
                cyc_end           = 1'b1;
            end else begin
                mon_d.tmo_cnt = mon_q.tmo_cnt + TMO_W'(1);
            end
        end

        // Pending level: set wins over clear
        if (zero_evt_i)   mon_d.pending = 1'b1;
        else if (cyc_end) mon_d.pending = 1'b0;

        // Lost-cycle history
        if (start_pkt_i || master_act) begin
            mon_d.one_roll = 1'b0;
        end else if (zero_evt_i) begin
            if (mon_q.one_roll) begin
                mon_d.evt.lost = 1'b1;
                mon_d.one_roll = 1'b0;
            end else begin
                mon_d.one_roll = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q           <= '0;
            mon_q.master_en <= 1'b1;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign pending_o       = mon_q.pending;
    assign evt_o           = mon_q.evt;
    assign master_active_o = master_act;
endmodule

// File: rtl/cycle_timer_mon.sv
module cycle_timer_mon
    import cyc_pkg::*;
#(
    parameter int OFFSET_MOD = 3072,
    parameter int COUNT_MOD  = 8000,
    parameter int SEC_W      = 7,
    parameter int TMO_TICKS  = 3072,
    parameter int OFF_W      = $clog2(OFFSET_MOD),
    parameter int CNT_W      = $clog2(COUNT_MOD),
    parameter int TIMER_W    = SEC_W + CNT_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en_i,
    input  logic               src_sel_i,
    input  logic               ext_cycle_i,
    input  logic               cycle_master_i,
    input  logic               start_pkt_i,
    input  logic               fair_gap_i,
    output logic [TIMER_W-1:0] timer_o,
    output logic               cyc_pending_o,
    output logic               cyc_started_o,
    output logic               cyc_done_o,
    output logic               cyc_lost_o,
    output logic               cyc_timeout_o,
    output logic               sec_inc_o,
    output logic               master_active_o
);
    logic             strobe_rise;
    logic             zero_evt;
    logic [OFF_W-1:0] offset;
    logic [CNT_W-1:0] count;
    logic [SEC_W-1:0] sec;
    cyc_evt_t         evt;

    cyc_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_cycle_i),
        .rise_o  (strobe_rise)
    );

    cyc_timer_core #(
        .OFFSET_MOD (OFFSET_MOD),
        .COUNT_MOD  (COUNT_MOD),
        .SEC_W      (SEC_W),
        .OFF_W      (OFF_W),
        .CNT_W      (CNT_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (tick_en_i),
        .src_sel_i     (src_sel_i),
        .strobe_rise_i (strobe_rise),
        .offset_o      (offset),
        .count_o       (count),
        .sec_o         (sec),
        .zero_evt_o    (zero_evt),
        .sec_inc_o     (sec_inc_o)
    );

    cyc_monitor #(
        .TMO_TICKS (TMO_TICKS)
    ) u_mon (
        .clk             (clk),
        .rst_n           (rst_n),
        .zero_evt_i      (zero_evt),
        .start_pkt_i     (start_pkt_i),
        .fair_gap_i      (fair_gap_i),
        .master_req_i    (cycle_master_i),
        .pending_o       (cyc_pending_o),
        .evt_o           (evt),
        .master_active_o (master_active_o)
    );

    assign timer_o       = {sec, count, offset};
    assign cyc_started_o = evt.started;
    assign cyc_done_o    = evt.done;
    assign cyc_lost_o    = evt.lost;
    assign cyc_timeout_o = evt.timeout;
endmodule

// File: rtl/cycle_timer_mon_chk.sv
module cycle_timer_mon_chk #(
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 13,
    parameter int TIMER_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en_i,
    input logic               src_sel_i,
    input logic               start_pkt_i,
    input logic               fair_gap_i,
    input logic [TIMER_W-1:0] timer_o,
    input logic               cyc_pending_o,
    input logic               cyc_started_o,
    input logic               cyc_done_o,
    input logic               cyc_lost_o,
    input logic               cyc_timeout_o,
    input logic               sec_inc_o,
    input logic               master_active_o
);
    logic [OFF_W-1:0] off_f;
    logic [CNT_W-1:0] cnt_f;
    assign off_f = timer_o[OFF_W-1:0];
    assign cnt_f = timer_o[OFF_W+CNT_W-1:OFF_W];

    assert_offset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_i && !src_sel_i) |=> $stable(off_f));

    assert_pending_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (off_f == '0 && $past(off_f) != '0) |-> cyc_pending_o);

    assert_started_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pkt_i |=> cyc_started_o);

    assert_done_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done_o |-> $past(fair_gap_i));

    assert_lost_not_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_lost_o |-> !$past(master_active_o));

    assert_timeout_drops_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_timeout_o |-> !master_active_o);

    assert_sec_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_inc_o |-> (cnt_f == '0 && off_f == '0));
endmodule

bind cycle_timer_mon cycle_timer_mon_chk #(
    .OFF_W   (OFF_W),
    .CNT_W   (CNT_W),
    .TIMER_W (TIMER_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_en_i       (tick_en_i),
    .src_sel_i       (src_sel_i),
    .start_pkt_i     (start_pkt_i),
    .fair_gap_i      (fair_gap_i),
    .timer_o         (timer_o),
    .cyc_pending_o   (cyc_pending_o),
    .cyc_started_o   (cyc_started_o),
    .cyc_done_o      (cyc_done_o),
    .cyc_lost_o      (cyc_lost_o),
    .cyc_timeout_o   (cyc_timeout_o),
    .sec_inc_o       (sec_inc_o),
    .master_active_o (master_active_o)
);

// File: tb/cycle_timer_mon_bench.sv
module cycle_timer_mon_bench;
    localparam int OM = 4;
    localparam int CM = 3;
    localparam int SW = 3;
    localparam int TT = 6;
    localparam int OW = 2;
    localparam int CW = 2;
    localparam int TW = SW + CW + OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, src = 1'b0, ext = 1'b0, mst = 1'b1, start = 1'b0, gap = 1'b0;
    logic [TW-1:0] timer;
    logic pend, started, done, lost, tmo, sinc, mact;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cycle_timer_mon #(
        .OFFSET_MOD (OM),
        .COUNT_MOD  (CM),
        .SEC_W      (SW),
        .TMO_TICKS  (TT)
    ) u_cycle_timer_mon (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_en_i       (en),
        .src_sel_i       (src),
        .ext_cycle_i     (ext),
        .cycle_master_i  (mst),
        .start_pkt_i     (start),
        .fair_gap_i      (gap),
        .timer_o         (timer),
        .cyc_pending_o   (pend),
        .cyc_started_o   (started),
        .cyc_done_o      (done),
        .cyc_lost_o      (lost),
        .cyc_timeout_o   (tmo),
        .sec_inc_o       (sinc),
        .master_active_o (mact)
    );

    typedef struct packed {
        logic       en;
        logic [3:0] sec;
        logic [3:0] cnt;
        logic [3:0] off;
        logic       sinc;
        logic       pend;
    } vec_t;

    localparam vec_t VECS [0:13] = '{
        '{1'b1, 4'd0, 4'd0, 4'd1, 1'b0, 1'b0},
        '{1'b1, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0},
        '{1'b1, 4'd0, 4'd0, 4'd3, 1'b0, 1'b0},
        '{1'b1, 4'd0, 4'd1, 4'd0, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'd1, 4'd0, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd1, 4'd1, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd1, 4'd2, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd1, 4'd3, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd2, 4'd0, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd2, 4'd1, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd2, 4'd2, 1'b0, 1'b1},
        '{1'b1, 4'd0, 4'd2, 4'd3, 1'b0, 1'b1},
        '{1'b1, 4'd1, 4'd0, 4'd0, 1'b1, 1'b1},
        '{1'b1, 4'd1, 4'd0, 4'd1, 1'b0, 1'b1}
    };

    function automatic int f_off();
        return int'(timer[OW-1:0]);
    endfunction
    function automatic int f_cnt();
        return int'(timer[OW+CW-1:OW]);
    endfunction
    function automatic int f_sec();
        return int'(timer[TW-1:OW+CW]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0; src = 1'b0; ext = 1'b0; start = 1'b0; gap = 1'b0; mst = m;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int hit;
        int first;

        // R9: reset state
        do_reset(1'b1);
        chk("R9 timer", int'(timer), 0);
        chk("R9 flags", int'({pend, started, done, lost, tmo, sinc}), 0);
        chk("R9 master_active", int'(mact), 1);

        // R1 R2 R4 R8: table walk, src low, node is master
        for (int v = 0; v < 14; v++) begin
            en = VECS[v].en;
            tick();
            chk($sformatf("R1 offset vec%0d", v), f_off(), int'(VECS[v].off));
            chk($sformatf("R2 count vec%0d", v), f_cnt(), int'(VECS[v].cnt));
            chk($sformatf("R2 seconds vec%0d", v), f_sec(), int'(VECS[v].sec));
            chk($sformatf("R8 sec_inc vec%0d", v), int'(sinc), int'(VECS[v].sinc));
            chk($sformatf("R4 pending vec%0d", v), int'(pend), int'(VECS[v].pend));
            chk($sformatf("R6 no lost as master vec%0d", v), int'(lost), 0);
        end

        // R5 R4: start then fair gap closes the cycle and clears pending
        do_reset(1'b1);
        en = 1'b1; tick(4); en = 1'b0;
        chk("R4 pending set", int'(pend), 1);
        start = 1'b1; tick(); start = 1'b0;
        chk("R5 started pulse", int'(started), 1);
        tick();
        chk("R5 started one clock", int'(started), 0);
        gap = 1'b1; tick(); gap = 1'b0;
        chk("R5 done pulse", int'(done), 1);
        chk("R4 pending cleared", int'(pend), 0);
        tick();
        chk("R5 done one clock", int'(done), 0);
        gap = 1'b1; tick(); gap = 1'b0;
        chk("R5 gap without cycle", int'(done), 0);

        // R7: timeout after TT edges without a fair gap
        do_reset(1'b1);
        start = 1'b1; tick(); start = 1'b0;
        hit = 0; first = 0;
        for (int k = 1; k <= TT + 2; k++) begin
            tick();
            if (tmo) begin
                hit++;
                if (first == 0) first = k;
            end
        end
        chk("R7 timeout edge", first, TT);
        chk("R7 timeout single pulse", hit, 1);
        chk("R7 master dropped", int'(mact), 0);
        gap = 1'b1; tick(); gap = 1'b0;
        chk("R7 cycle closed no done", int'(done), 0);
        mst = 1'b0; tick(); mst = 1'b1; tick();
        chk("R7 master re-armed", int'(mact), 1);

        // R6: two rollovers without start while not master
        do_reset(1'b0);
        en = 1'b1;
        hit = 0; first = 0;
        for (int k = 1; k <= 8; k++) begin
            tick();
            if (lost) begin
                hit++;
                if (first == 0) first = k;
            end
        end
        chk("R6 lost edge", first, 8);
        chk("R6 lost count", hit, 1);

        // R6: start between rollovers clears history
        do_reset(1'b0);
        en = 1'b1;
        hit = 0;
        for (int k = 1; k <= 8; k++) begin
            start = (k == 5);
            tick();
            if (lost) hit++;
        end
        start = 1'b0;
        chk("R6 start clears history", hit, 0);

        // R3: external strobe source
        do_reset(1'b1);
        src = 1'b1;
        ext = 1'b1;
        tick(2);
        chk("R3 strobe not yet", f_cnt(), 0);
        tick();
        chk("R3 strobe count", f_cnt(), 1);
        chk("R3 strobe offset", f_off(), 0);
        chk("R4 pending on strobe", int'(pend), 1);
        ext = 1'b0;
        en = 1'b1; tick(4); en = 1'b0;
        chk("R3 rollover offset", f_off(), 0);
        chk("R3 rollover keeps count", f_cnt(), 1);
        src = 1'b0;
        tick(2);
        ext = 1'b1; tick(4); ext = 1'b0; tick();
        chk("R3 strobe ignored count", f_cnt(), 1);
        chk("R3 strobe ignored offset", f_off(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule